// File: doc/BRIEF.md
# Deferred Condition Flag Evaluator

This block turns the record of the most recent arithmetic, logic or multiply operation into condition flags and merges them into a status word. A processor that skips flag computation on every instruction keeps the operation class, the operand size, both source operands, the result and the upper half of a multiply. It presents them here only when a later instruction, an exception or a context switch needs the flags. The block evaluates negative, zero, overflow and carry at the chosen operand width and writes them back through a caller-supplied update mask. The extend bit is always cleared, except for the pass-through class.

The evaluation is combinational. A parameter selects whether the merged status word is registered, giving one cycle of latency, or driven straight to the output. Subtract and compare invert the source operand before evaluation and invert the carry after it. The merge-with-carry class puts its carry into a separate flag bit. When extended arithmetic is active, a zero result cannot set the zero flag, so the zero condition of a multi-word chain accumulates correctly.

Top module: `ccEvaluator`

## Requirements
- R1: While reset is asserted, and at the first sample after it, the registered status output is 0.
- R2: Op class 0 (add) uses the sign bit at the operand width, chosen by size code 0/1/2 as bit 7/15/31. If the result sign is 1, N is set, V is set when both operand signs are 0, and carry is set when both are 1. If the result sign is 0, Z is set when the width-masked result is zero, V is set when both operand signs are 1, and carry is set when either operand sign is 1. Flag bits are C=0, V=1, Z=2, N=3, X=4, R=6.
- R3: Op classes 1 (subtract) and 2 (compare) apply the R2 rules to the inverted source operand and then invert the carry.
- R4: Op class 3 (merge with carry) applies the R2 rules at 32 bits for every size code. It places the carry in bit 6 (R) and never sets bit 0 (C).
- R5: Op class 4 (move, logic and shift) sets N from the result sign at the operand width. Otherwise it sets Z when the width-masked result is zero. It never sets V or C.
- R6: Op class 5 (signed multiply) forms the 64-bit value {mof, res}. It sets Z when that value is zero and N when it is negative. It sets V when mof differs from the sign extension of res. Size is ignored.
- R7: Op class 6 (unsigned multiply) sets Z when {mof, res} is zero, N from mof bit 31, and V when mof is nonzero. Size is ignored.
- R8: The effective mask is the update mask with bit 4 (X) added. Status bits under it are replaced by the new flags, and all other bits keep their statusIn value.
- R9: With xIn = 1, a computed Z of 1 is not written and the old Z is kept. A computed Z of 0 still clears Z.
- R10: Size code 3 yields no new flags for classes 0 to 4 except class 3, so the bits under the effective mask are only cleared.
- R11: Op class 7 (flags live) passes statusIn to the output unchanged, including X.
- R12: With the output register enabled, the output changes only at a rising clock edge. It shows the result for the inputs present at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opClass | input | 3 | Recorded operation class |
| sizeCode | input | 2 | Operand size code (byte, word, dword, invalid) |
| srcVal | input | DATA_W | Recorded source operand |
| dstVal | input | DATA_W | Recorded destination operand |
| resVal | input | DATA_W | Recorded result |
| mofVal | input | DATA_W | Upper half of a multiply result |
| statusIn | input | STAT_W | Current status word |
| updMask | input | STAT_W | Flags the operation may update |
| xIn | input | 1 | Extended-arithmetic flag of the operation |
| statusOut | output | STAT_W | Merged status word |

## Verification
Every fault in this block shows up on the status word. A wrong width strobe or sign pick flips N, V or carry for one size code only. A mask fault alters bits the operation must not touch. Because the path holds no state beyond the output register, every such error is visible at the first edge after the offending inputs. The sweep therefore compares every cycle across all class, size and extend combinations, using operands chosen to hit each sign triple and width-masked zero.

// File: rtl/ccEvalPkg.sv
package ccEvalPkg;

  localparam int unsigned FLAG_C    = 0;
  localparam int unsigned FLAG_V    = 1;
  localparam int unsigned FLAG_Z    = 2;
  localparam int unsigned FLAG_N    = 3;
  localparam int unsigned FLAG_X    = 4;
  localparam int unsigned FLAG_R    = 6;
  localparam int unsigned FLAG_BITS = 7;

  typedef enum logic [2:0] {
    OP_ADD   = 3'd0,
    OP_SUB   = 3'd1,
    OP_CMP   = 3'd2,
    OP_MCP   = 3'd3,
    OP_LOGIC = 3'd4,
    OP_MULS  = 3'd5,
    OP_MULU  = 3'd6,
    OP_LIVE  = 3'd7
  } opClass_e;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_DWORD = 2'd2,
    SZ_BAD   = 2'd3
  } size_e;

  // widthSel is one-hot: bit 0 byte, bit 1 half, bit 2 full width
  typedef struct packed {
    logic       addRules;
    logic       invSrc;
    logic       carryToR;
    logic       logicRules;
    logic       mulSigned;
    logic       mulUnsigned;
    logic       passThru;
    logic [2:0] widthSel;
  } ccStrobe_t;

endpackage

// File: rtl/ccControl.sv
module ccControl
  import ccEvalPkg::*;
(
  input  opClass_e  opClass,
  input  size_e     sizeCode,
  output ccStrobe_t strobe
);

  logic [2:0] sizeSel;

  always_comb begin
    unique case (sizeCode)
      SZ_BYTE:  sizeSel = 3'b001;
      SZ_WORD:  sizeSel = 3'b010;
      SZ_DWORD: sizeSel = 3'b100;
      default:  sizeSel = 3'b000;
    endcase
  end

  always_comb begin
    strobe = '0;
    unique case (opClass)
      OP_ADD: begin
        strobe.addRules = 1'b1;
        strobe.widthSel = sizeSel;
      end
      OP_SUB, OP_CMP: begin
        strobe.addRules = 1'b1;
        strobe.invSrc   = 1'b1;
        strobe.widthSel = sizeSel;
      end
      OP_MCP: begin
        strobe.addRules = 1'b1;
        strobe.carryToR = 1'b1;
        strobe.widthSel = 3'b100;
      end
      OP_LOGIC: begin
        strobe.logicRules = 1'b1;
        strobe.widthSel   = sizeSel;
      end
      OP_MULS: strobe.mulSigned   = 1'b1;
      OP_MULU: strobe.mulUnsigned = 1'b1;
      default: strobe.passThru    = 1'b1;
    endcase
  end

endmodule

// File: rtl/ccDatapath.sv
module ccDatapath
  import ccEvalPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int STAT_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ccStrobe_t         strobe,
  input  logic [DATA_W-1:0] srcVal,
  input  logic [DATA_W-1:0] dstVal,
  input  logic [DATA_W-1:0] resVal,
  input  logic [DATA_W-1:0] mofVal,
  input  logic [STAT_W-1:0] statusIn,
  input  logic [STAT_W-1:0] updMask,
  input  logic              xIn,
  output logic [STAT_W-1:0] statusNext
);

  localparam int HALF_W = DATA_W / 2;
  localparam int QUAR_W = DATA_W / 4;
  localparam int PROD_W = 2 * DATA_W;

  logic [DATA_W-1:0]    srcEff;
  logic                 signA, signD, signR, resZero, anyWidth;
  logic                 addN, addZ, addV, addCy;
  logic [PROD_W-1:0]    prodVal;
  logic                 prodZero;
  logic [FLAG_BITS-1:0] newFlags;
  logic [STAT_W-1:0]    effMask;
  logic [STAT_W-1:0]    flagsWide;

  assign srcEff   = strobe.invSrc ? ~srcVal : srcVal;
  assign anyWidth = |strobe.widthSel;

  // sign bits and zero test at the selected operand width
  assign signA = |(strobe.widthSel & {srcEff[DATA_W-1], srcEff[HALF_W-1], srcEff[QUAR_W-1]});
  assign signD = |(strobe.widthSel & {dstVal[DATA_W-1], dstVal[HALF_W-1], dstVal[QUAR_W-1]});
  assign signR = |(strobe.widthSel & {resVal[DATA_W-1], resVal[HALF_W-1], resVal[QUAR_W-1]});
  assign resZero = |(strobe.widthSel & {~|resVal, ~|resVal[HALF_W-1:0], ~|resVal[QUAR_W-1:0]});

  always_comb begin
    addN  = 1'b0;
    addZ  = 1'b0;
    addV  = 1'b0;
    addCy = 1'b0;
    if (anyWidth) begin
      if (signR) begin
        addN  = 1'b1;
        addV  = ~signA & ~signD;
        addCy = signA & signD;
      end else begin
        addZ  = resZero;
        addV  = signA & signD;
        addCy = signA | signD;
      end
      addCy = addCy ^ strobe.invSrc;
    end
  end

  assign prodVal  = {mofVal, resVal};
  assign prodZero = ~|prodVal;

  always_comb begin
    newFlags = '0;
    if (strobe.addRules) begin
      newFlags[FLAG_N] = addN;
      newFlags[FLAG_Z] = addZ;
      newFlags[FLAG_V] = addV;
      if (strobe.carryToR) newFlags[FLAG_R] = addCy;
      else                 newFlags[FLAG_C] = addCy;
    end else if (strobe.logicRules) begin
      newFlags[FLAG_N] = signR;
      newFlags[FLAG_Z] = anyWidth & ~signR & resZero;
    end else if (strobe.mulSigned) begin
      newFlags[FLAG_Z] = prodZero;
      newFlags[FLAG_N] = prodVal[PROD_W-1];
      newFlags[FLAG_V] = mofVal != {DATA_W{resVal[DATA_W-1]}};
    end else if (strobe.mulUnsigned) begin
      newFlags[FLAG_Z] = prodZero;
      newFlags[FLAG_N] = prodVal[PROD_W-1];
      newFlags[FLAG_V] = |mofVal;
    end
  end

  always_comb begin
    effMask         = updMask;
    effMask[FLAG_X] = 1'b1;
    if (xIn && newFlags[FLAG_Z]) effMask[FLAG_Z] = 1'b0;
  end

  assign flagsWide  = {{(STAT_W-FLAG_BITS){1'b0}}, newFlags} & effMask;
  assign statusNext = strobe.passThru ? statusIn : ((statusIn & ~effMask) | flagsWide);

  AST_NZ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(newFlags[FLAG_N] && newFlags[FLAG_Z])); // R5

  AST_UNMASKED_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.passThru |-> ((statusNext ^ statusIn) & ~(updMask | STAT_W'(1 << FLAG_X))) == '0); // R8

  AST_Z_NOT_SET_EXT: assert property (@(posedge clk) disable iff (!rstN)
    (xIn && !statusIn[FLAG_Z]) |-> !statusNext[FLAG_Z]); // R9

  AST_MCP_NO_C: assert property (@(posedge clk) disable iff (!rstN)
    strobe.carryToR |-> !newFlags[FLAG_C]); // R4

endmodule

// File: rtl/ccEvaluator.sv
module ccEvaluator
  import ccEvalPkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int STAT_W  = 32,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        opClass,
  input  logic [1:0]        sizeCode,
  input  logic [DATA_W-1:0] srcVal,
  input  logic [DATA_W-1:0] dstVal,
  input  logic [DATA_W-1:0] resVal,
  input  logic [DATA_W-1:0] mofVal,
  input  logic [STAT_W-1:0] statusIn,
  input  logic [STAT_W-1:0] updMask,
  input  logic              xIn,
  output logic [STAT_W-1:0] statusOut
);

  ccStrobe_t         strobe;
  logic [STAT_W-1:0] statusNext;

  ccControl i_control (
    .opClass  (opClass_e'(opClass)),
    .sizeCode (size_e'(sizeCode)),
    .strobe   (strobe)
  );

  ccDatapath #(
    .DATA_W (DATA_W),
    .STAT_W (STAT_W)
  ) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .srcVal     (srcVal),
    .dstVal     (dstVal),
    .resVal     (resVal),
    .mofVal     (mofVal),
    .statusIn   (statusIn),
    .updMask    (updMask),
    .xIn        (xIn),
    .statusNext (statusNext)
  );

  generate
    if (REG_OUT) begin : g_regOut
      always_ff @(posedge clk) begin
        if (!rstN) statusOut <= '0;
        else       statusOut <= statusNext;
      end

      AST_LIVE_PASS: assert property (@(posedge clk) disable iff (!rstN)
        (opClass == 3'd7) |=> statusOut == $past(statusIn)); // R11

      AST_X_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
        (opClass != 3'd7) |=> !statusOut[FLAG_X]); // R8
    end else begin : g_combOut
      assign statusOut = statusNext;

      AST_LIVE_PASS: assert property (@(posedge clk) disable iff (!rstN)
        (opClass == 3'd7) |-> statusOut == statusIn); // R11

      AST_X_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
        (opClass != 3'd7) |-> !statusOut[FLAG_X]); // R8
    end
  endgenerate

endmodule

// File: tb/test_ccEvaluator.sv
`timescale 1ns/1ps
module test_ccEvaluator;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  opClass = '0;
  logic [1:0]  sizeCode = '0;
  logic [31:0] srcVal = '0, dstVal = '0, resVal = '0, mofVal = '0;
  logic [31:0] statusIn = '0, updMask = '0;
  logic        xIn = 1'b0;
  logic [31:0] statusOut;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [31:0] seed = 32'h1234_5679;

  always #4 clk = ~clk;

  ccEvaluator i_ccEvaluator (
    .clk(clk), .rstN(rstN), .opClass(opClass), .sizeCode(sizeCode),
    .srcVal(srcVal), .dstVal(dstVal), .resVal(resVal), .mofVal(mofVal),
    .statusIn(statusIn), .updMask(updMask), .xIn(xIn), .statusOut(statusOut)
  );

  function automatic logic [31:0] nextRand(input logic [31:0] v);
    logic [31:0] t;
    t = v ^ (v << 13);
    t = t ^ (t >> 17);
    t = t ^ (t << 5);
    return t;
  endfunction

  // reference model written from the requirements
  function automatic logic [31:0] refStatus(input int op, input int sz,
      input logic [31:0] s, input logic [31:0] d, input logic [31:0] r,
      input logic [31:0] m, input logic [31:0] st, input logic [31:0] mk,
      input logic x);
    logic [6:0]  f;
    logic [31:0] eff;
    logic        sa, sd, sr, zz, cy;
    logic signed [63:0] p;
    int bits;
    f = '0;
    cy = 1'b0;
    if (op == 7) return st;
    if (op == 3)      bits = 32;
    else if (sz == 0) bits = 8;
    else if (sz == 1) bits = 16;
    else if (sz == 2) bits = 32;
    else              bits = 0;
    if (op == 5) begin
      p = {m, r};
      f[2] = (p == 0);
      f[3] = (p < 0);
      f[1] = ($signed(m) != ($signed(r) >>> 31));
    end else if (op == 6) begin
      f[2] = ({m, r} == 64'd0);
      f[3] = m[31];
      f[1] = (m != 0);
    end else if (bits != 0) begin
      sa = (op == 1 || op == 2) ? !s[bits-1] : s[bits-1];
      sd = d[bits-1];
      sr = r[bits-1];
      zz = ((r << (32 - bits)) == 32'd0);
      if (op == 4) begin
        f[3] = sr;
        f[2] = !sr && zz;
      end else begin
        case ({sr, sa, sd})
          3'b100:          begin f[3] = 1; f[1] = 1; end
          3'b101, 3'b110:  f[3] = 1;
          3'b111:          begin f[3] = 1; cy = 1; end
          3'b000:          f[2] = zz;
          3'b001, 3'b010:  begin f[2] = zz; cy = 1; end
          default:         begin f[2] = zz; f[1] = 1; cy = 1; end
        endcase
        if (op == 1 || op == 2) cy = !cy;
        if (op == 3) f[6] = cy;
        else         f[0] = cy;
      end
    end
    eff = mk | 32'h10;
    if (x && f[2]) eff[2] = 1'b0;
    return (st & ~eff) | ({25'd0, f} & eff);
  endfunction

  function automatic string reqOf(input int op, input int sz);
    if (sz == 3 && op <= 4 && op != 3) return "R10";
    case (op)
      0: return "R2";
      1, 2: return "R3";
      3: return "R4";
      4: return "R5";
      5: return "R6";
      6: return "R7";
      default: return "R11";
    endcase
  endfunction

  task automatic compare(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic applyOp(input int op, input int sz, input logic [31:0] s,
      input logic [31:0] d, input logic [31:0] r, input logic [31:0] m,
      input logic [31:0] st, input logic [31:0] mk, input logic x);
    @(negedge clk);
    opClass = op[2:0]; sizeCode = sz[1:0];
    srcVal = s; dstVal = d; resVal = r; mofVal = m;
    statusIn = st; updMask = mk; xIn = x;
    @(posedge clk);
    #1;
  endtask

  task automatic runCheck(input string req, input int op, input int sz,
      input logic [31:0] s, input logic [31:0] d, input logic [31:0] r,
      input logic [31:0] m, input logic [31:0] st, input logic [31:0] mk,
      input logic x);
    applyOp(op, sz, s, d, r, m, st, mk, x);
    compare(req, statusOut, refStatus(op, sz, s, d, r, m, st, mk, x));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    compare("R1", statusOut, 32'd0);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk);
    #1;
    compare("R1", statusOut, 32'd0);

    // R8: empty mask still clears X, other bits kept
    applyOp(0, 2, 32'h1, 32'h1, 32'h2, 0, 32'hFFFF_FFFF, 32'h0, 1'b0);
    compare("R8", statusOut, 32'hFFFF_FFEF);
    // R8: full mask, positive nonzero result with no operand signs
    applyOp(0, 2, 32'h1, 32'h1, 32'h2, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
    compare("R8", statusOut, 32'h0000_0000);
    // R9: zero result under extend keeps old Z
    applyOp(0, 2, 0, 0, 0, 0, 32'h0000_0004, 32'hFFFF_FFFF, 1'b1);
    compare("R9", statusOut, 32'h0000_0004);
    applyOp(0, 2, 0, 0, 0, 0, 32'hFFFF_FF00, 32'hFFFF_FFFF, 1'b1);
    compare("R9", statusOut, 32'h0000_0000);
    applyOp(0, 2, 0, 0, 32'h5, 0, 32'h0000_0004, 32'hFFFF_FFFF, 1'b1);
    compare("R9", statusOut, 32'h0000_0000);
    // R4: both signs set, negative result, carry into bit 6
    applyOp(3, 0, 32'h8000_0000, 32'h8000_0000, 32'h8000_0000, 0, 0, 32'hFF, 1'b0);
    compare("R4", statusOut, 32'h0000_0048);
    // R3: subtract 1-1, source inverted: sa=1, sd=0, zero result -> Z, C inverted to 0
    applyOp(1, 2, 32'h1, 32'h1, 32'h0, 0, 0, 32'hFF, 1'b0);
    compare("R3", statusOut, 32'h0000_0004);
    // R6: negative product with clean sign extension
    applyOp(5, 3, 0, 0, 32'h8000_0000, 32'hFFFF_FFFF, 0, 32'hFF, 1'b0);
    compare("R6", statusOut, 32'h0000_0008);

    // R12: inputs change at negedge, output holds until the next rising edge
    applyOp(7, 0, 0, 0, 0, 0, 32'hA5A5_0000, 32'hFF, 1'b0);
    @(negedge clk);
    opClass = 3'd7; statusIn = 32'h0000_1234;
    #1;
    compare("R12", statusOut, 32'hA5A5_0000);
    @(posedge clk);
    #1;
    compare("R12", statusOut, 32'h0000_1234);

    // sweep over classes, sizes, extend and operand patterns
    for (int op = 0; op < 8; op++) begin
      for (int sz = 0; sz < 4; sz++) begin
        for (int x = 0; x < 2; x++) begin
          for (int k = 0; k < 24; k++) begin
            logic [31:0] s, d, r, m, st, mk;
            seed = nextRand(seed); s = seed;
            seed = nextRand(seed); d = seed;
            seed = nextRand(seed); r = seed;
            seed = nextRand(seed); m = seed;
            seed = nextRand(seed); st = seed;
            mk = k[0] ? 32'hFFFF_FFFF : 32'h0000_004F;
            case (k)
              0: r = 32'd0;
              1: r = 32'h1234_0000;
              2: r = 32'h5600_0000;
              3: begin s = 32'h8080_8080; d = 32'h8080_8080; r = 32'h8080_8080; end
              4: begin s = 32'h0; d = 32'h0; r = 32'hFFFF_FFFF; end
              5: begin s = 32'h8080_8080; d = 32'h0; r = 32'h0; end
              6: begin m = 32'd0; r = 32'd0; end
              7: begin m = 32'hFFFF_FFFF; r = 32'h8000_0001; end
              8: begin m = 32'd0; r = 32'h7FFF_FFFF; end
              9: begin s = 32'hFFFF_FFFF; d = 32'hFFFF_FFFF; r = 32'h0; end
              default: ;
            endcase
            runCheck(reqOf(op, sz), op, sz, s, d, r, m, st, mk, x[0]);
          end
        end
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule